// File: doc/BRIEF.md
# Command-Frame SPI Slave

This block is the peripheral end of a four-wire synchronous serial link. It decodes short command frames sent by a host. While the select line is inactive the slave stays asleep. It keeps its serial output released and ignores the clock and data pins. When the host selects it, the slave collects one command byte. The value of that byte decides what happens next. The slave may gather argument bytes and then issue a one-cycle execute pulse, or it may shift a multi-byte reply back to the host. A command the slave does not know sends it back to sleep.

The serial pins are asynchronous to the system clock. Each is passed through a two-flop synchronizer, and the clock edges are detected in the system domain. Data from the host is sampled on the rising serial-clock edge, and reply data changes on the falling edge. Both run most significant bit first. If the select goes inactive at any point, the frame is dropped at once. A watchdog releases the bus when a select arrives and no serial-clock edge follows. The slave then stays off the bus until the select is released.

Top module: `spiCmdSlave`

## Requirements
- R1: While selN is high, misoOe and miso stay 0, and SCK and MOSI activity causes neither an execute pulse nor a reply.
- R2: A falling selN clears the bit counter. Clock pulses seen while the slave was deselected therefore do not shift the boundaries of the next frame's bytes.
- R3: Command 0x01 takes two argument bytes. argOut becomes {first byte, second byte}, and execStrobe is high for exactly one system cycle after the second byte ends.
- R4: Command 0x02 raises misoOe and shifts the four bytes of replyData out on miso, most significant bit first. Each bit is valid at the SCK rising edge and changes after the SCK falling edge. After the 32nd bit, misoOe returns to 0.
- R5: Any other command value returns the slave to sleep. Until the next select, misoOe stays 0 and no execute pulse occurs.
- R6: A rising selN ends the frame. misoOe drops within four system cycles, partial argument bytes are discarded, and no execute pulse follows. This holds even when the rise coincides with the final argument bit.
- R7: If no SCK edge follows a select within TIMEOUT_CYCLES system cycles, the slave leaves the bus until selN rises. Once the first edge has arrived, a later pause does not trigger the watchdog.
- R8: A low rstN forces sleep, with misoOe low and execStrobe low.
- R9: MOSI is sampled on SCK rising edges, most significant bit first. cmdOut holds the last command byte received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock from host |
| mosi | input | 1 | Serial data from host |
| selN | input | 1 | Active-low slave select |
| miso | output | 1 | Serial reply data, 0 when not driven |
| misoOe | output | 1 | Output enable for the miso pad driver |
| cmdOut | output | 8 | Last command byte received |
| argOut | output | 8*ARG_BYTES | Argument bytes, first byte most significant |
| execStrobe | output | 1 | One-cycle pulse when an argument command completes |
| replyData | input | 8*REPLY_BYTES | Reply word, sent most significant byte first |

## Verification
Completion of the last argument bit and a deselect can land in the same system cycle. This happens because SCK and selN go through synchronizers of equal depth. The bench provokes the clash by raising selN in the same instant as the final SCK rising edge. It then judges the result by confirming that the execute-pulse count does not change. A following complete frame must still deliver exactly its own two arguments.

// File: rtl/spiCmdPkg.sv
package spiCmdPkg;
  typedef enum logic [1:0] {ST_SLEEP, ST_CMD, ST_ARG, ST_REPLY} ctlState_t;

  typedef struct packed {
    logic clr;        // restart bit counter for a new frame
    logic shiftEn;    // accept serial clock edges
    logic capCmd;     // latch received byte as command
    logic capArg;     // append received byte to arguments
    logic loadReply;  // load reply word into transmit shifter
    logic txEn;       // drive miso
  } dpCtl_t;

  localparam logic [7:0] CMD_WRITE = 8'h01;
  localparam logic [7:0] CMD_READ  = 8'h02;
endpackage

// File: rtl/spiCmdDatapath.sv
module spiCmdDatapath
  import spiCmdPkg::*;
#(
  parameter int ARG_BYTES   = 2,
  parameter int REPLY_BYTES = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     sck,
  input  logic                     mosi,
  input  logic                     selN,
  input  dpCtl_t                   ctl,
  input  logic [8*REPLY_BYTES-1:0] replyData,
  output logic                     selActive,
  output logic                     selRise,
  output logic                     sckRise,
  output logic                     sckFall,
  output logic                     byteDone,
  output logic [7:0]               rxByte,
  output logic [7:0]               cmdOut,
  output logic [8*ARG_BYTES-1:0]   argOut,
  output logic                     miso
);
  localparam int ARG_W   = 8 * ARG_BYTES;
  localparam int REPLY_W = 8 * REPLY_BYTES;
  localparam logic [2:0] SYNC_INIT = 3'b100;  // {selN, sck, mosi}

  logic [2:0] rawIn, syncA, syncB;
  logic       sckDly, selActDly;
  logic [2:0] bitCnt;
  logic [6:0] shiftIn;
  logic [REPLY_W-1:0] txReg;
  logic       skipFall;
  logic [ARG_W-1:0] argReg;

  assign rawIn = {selN, sck, mosi};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA     <= SYNC_INIT;
      syncB     <= SYNC_INIT;
      sckDly    <= 1'b0;
      selActDly <= 1'b0;
    end else begin
      syncA     <= rawIn;
      syncB     <= syncA;
      sckDly    <= syncB[1];
      selActDly <= ~syncB[2];
    end
  end

  assign selActive = ~syncB[2];
  assign selRise   = selActive & ~selActDly;
  assign sckRise   = syncB[1] & ~sckDly;
  assign sckFall   = ~syncB[1] & sckDly;
  assign rxByte    = {shiftIn, syncB[0]};
  assign byteDone  = ctl.shiftEn & sckRise & (bitCnt == 3'd7);

  // receive shifter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt  <= '0;
      shiftIn <= '0;
      cmdOut  <= '0;
    end else begin
      if (ctl.clr) begin
        bitCnt <= '0;
      end else if (ctl.shiftEn && sckRise) begin
        shiftIn <= rxByte[6:0];
        bitCnt  <= bitCnt + 3'd1;
      end
      if (ctl.capCmd) cmdOut <= rxByte;
    end
  end

  // argument collection, variant picked by argument count
  if (ARG_BYTES == 1) begin : gArgOne
    always_ff @(posedge clk or negedge rstN)
      if (!rstN)           argReg <= '0;
      else if (ctl.capArg) argReg <= rxByte;
  end else begin : gArgMany
    always_ff @(posedge clk or negedge rstN)
      if (!rstN)           argReg <= '0;
      else if (ctl.capArg) argReg <= {argReg[ARG_W-9:0], rxByte};
  end
  assign argOut = argReg;

  // transmit shifter: first falling edge after load only presents bit 0 of the frame
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txReg    <= '0;
      skipFall <= 1'b0;
    end else if (ctl.loadReply) begin
      txReg    <= replyData;
      skipFall <= 1'b1;
    end else if (ctl.txEn && sckFall) begin
      if (skipFall) skipFall <= 1'b0;
      else          txReg    <= {txReg[REPLY_W-2:0], 1'b0};
    end
  end

  assign miso = ctl.txEn & txReg[REPLY_W-1];
endmodule

// File: rtl/spiCmdControl.sv
module spiCmdControl
  import spiCmdPkg::*;
#(
  parameter int TIMEOUT_CYCLES = 64,
  parameter int ARG_BYTES      = 2,
  parameter int REPLY_BYTES    = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       selActive,
  input  logic       selRise,
  input  logic       sckRise,
  input  logic       sckFall,
  input  logic       byteDone,
  input  logic [7:0] rxByte,
  output dpCtl_t     ctl,
  output ctlState_t  state,
  output logic       execStrobe,
  output logic       wdogExpire
);
  localparam int MAX_BYTES = (ARG_BYTES > REPLY_BYTES) ? ARG_BYTES : REPLY_BYTES;
  localparam int CNT_W     = $clog2(MAX_BYTES + 1);
  localparam int WD_W      = $clog2(TIMEOUT_CYCLES + 1);
  localparam logic [CNT_W-1:0] ARG_LAST   = CNT_W'(ARG_BYTES - 1);
  localparam logic [CNT_W-1:0] REPLY_LAST = CNT_W'(REPLY_BYTES - 1);
  localparam logic [WD_W-1:0]  WD_LAST    = WD_W'(TIMEOUT_CYCLES - 1);

  ctlState_t        nxt;
  logic [CNT_W-1:0] byteCnt;
  logic [WD_W-1:0]  wdCnt;
  logic             sawEdge, anyEdge, execNext;

  assign anyEdge = sckRise | sckFall;

  always_comb begin
    nxt        = state;
    ctl        = '0;
    wdogExpire = 1'b0;
    execNext   = 1'b0;
    ctl.shiftEn = (state != ST_SLEEP);
    ctl.txEn    = (state == ST_REPLY);
    unique case (state)
      ST_SLEEP: if (selRise) begin
        ctl.clr = 1'b1;
        nxt     = ST_CMD;
      end
      ST_CMD: begin
        if (byteDone) begin
          ctl.capCmd = 1'b1;
          if (rxByte == CMD_WRITE)     nxt = ST_ARG;
          else if (rxByte == CMD_READ) begin
            ctl.loadReply = 1'b1;
            nxt           = ST_REPLY;
          end else                     nxt = ST_SLEEP;
        end else if (!sawEdge && !anyEdge && wdCnt == WD_LAST) begin
          wdogExpire = 1'b1;
          nxt        = ST_SLEEP;
        end
      end
      ST_ARG: if (byteDone) begin
        ctl.capArg = 1'b1;
        if (byteCnt == ARG_LAST) begin
          execNext = 1'b1;
          nxt      = ST_SLEEP;
        end
      end
      ST_REPLY: if (byteDone && byteCnt == REPLY_LAST) nxt = ST_SLEEP;
      default: nxt = ST_SLEEP;
    endcase
    // deselect overrides everything in the same cycle
    if (state != ST_SLEEP && !selActive) begin
      nxt           = ST_SLEEP;
      ctl.capCmd    = 1'b0;
      ctl.capArg    = 1'b0;
      ctl.loadReply = 1'b0;
      wdogExpire    = 1'b0;
      execNext      = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_SLEEP;
      byteCnt    <= '0;
      wdCnt      <= '0;
      sawEdge    <= 1'b0;
      execStrobe <= 1'b0;
    end else begin
      state      <= nxt;
      execStrobe <= execNext;
      if (nxt != state)  byteCnt <= '0;
      else if (byteDone) byteCnt <= byteCnt + CNT_W'(1);
      if (state != ST_CMD) begin
        wdCnt   <= '0;
        sawEdge <= 1'b0;
      end else begin
        wdCnt <= wdCnt + WD_W'(1);
        if (anyEdge) sawEdge <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/spiCmdSlave.sv
module spiCmdSlave
  import spiCmdPkg::*;
#(
  parameter int TIMEOUT_CYCLES = 64,
  parameter int ARG_BYTES      = 2,
  parameter int REPLY_BYTES    = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     sck,
  input  logic                     mosi,
  input  logic                     selN,
  output logic                     miso,
  output logic                     misoOe,
  output logic [7:0]               cmdOut,
  output logic [8*ARG_BYTES-1:0]   argOut,
  output logic                     execStrobe,
  input  logic [8*REPLY_BYTES-1:0] replyData
);
  dpCtl_t     ctl;
  ctlState_t  ctlState;
  logic       selActive, selRise, sckRise, sckFall, byteDone, wdogExpire;
  logic [7:0] rxByte;

  spiCmdDatapath #(.ARG_BYTES(ARG_BYTES), .REPLY_BYTES(REPLY_BYTES)) uDp (
    .clk, .rstN, .sck, .mosi, .selN, .ctl, .replyData,
    .selActive, .selRise, .sckRise, .sckFall, .byteDone, .rxByte,
    .cmdOut, .argOut, .miso
  );

  spiCmdControl #(
    .TIMEOUT_CYCLES(TIMEOUT_CYCLES), .ARG_BYTES(ARG_BYTES), .REPLY_BYTES(REPLY_BYTES)
  ) uCtl (
    .clk, .rstN, .selActive, .selRise, .sckRise, .sckFall, .byteDone, .rxByte,
    .ctl, .state(ctlState), .execStrobe, .wdogExpire
  );

  assign misoOe = ctl.txEn;
endmodule

// File: rtl/spiCmdSlave_chk.sv
module spiCmdSlave_chk
  import spiCmdPkg::*;
(
  input logic      clk,
  input logic      rstN,
  input logic      selActive,
  input logic      misoOe,
  input logic      miso,
  input logic      execStrobe,
  input logic      wdogExpire,
  input ctlState_t ctlState
);
  AST_QUIET_WHEN_RELEASED: assert property (@(posedge clk) disable iff (!rstN)
    !misoOe |-> !miso);                                              // R1
  AST_DESELECT_RELEASES: assert property (@(posedge clk) disable iff (!rstN)
    !selActive |=> !misoOe);                                         // R6
  AST_EXEC_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    execStrobe |=> !execStrobe);                                     // R3
  AST_EXEC_WHILE_SELECTED: assert property (@(posedge clk) disable iff (!rstN)
    execStrobe |-> $past(selActive));                                // R6
  AST_WDOG_OFF_BUS: assert property (@(posedge clk) disable iff (!rstN)
    wdogExpire |=> (ctlState == ST_SLEEP && !misoOe));               // R7
  AST_RESET_SLEEPS: assert property (@(posedge clk)
    $rose(rstN) |-> (!misoOe && !execStrobe && ctlState == ST_SLEEP)); // R8
endmodule

bind spiCmdSlave spiCmdSlave_chk uChk (
  .clk(clk), .rstN(rstN), .selActive(selActive), .misoOe(misoOe), .miso(miso),
  .execStrobe(execStrobe), .wdogExpire(wdogExpire), .ctlState(ctlState)
);

// File: tb/spiCmdSlave_test.sv
`timescale 1ns/1ps
module spiCmdSlave_test;
  localparam int HALF = 6;  // system cycles per SCK half period

  logic clk = 0, rstN = 0, sck = 0, mosi = 0, selN = 1;
  logic miso, misoOe, execStrobe;
  logic [7:0]  cmdOut;
  logic [15:0] argOut;
  logic [31:0] replyData = '0;

  int checks = 0, errors = 0;
  int execCount = 0, oeCycles = 0;
  logic [15:0] lastArg = '0;

  spiCmdSlave uut (.*);

  always #4 clk = ~clk;

  always @(posedge clk) begin
    if (execStrobe) begin execCount++; lastArg <= argOut; end
    if (misoOe) oeCycles++;
  end

  // each entry: {command, payload}; payload is args, reply word or trailing bytes
  localparam logic [39:0] VEC [6] = '{
    40'h01_0000_1234, 40'h02_DEAD_BEEF, 40'h7F_0000_5A5A,
    40'h01_0000_FF00, 40'h02_8000_0001, 40'h00_0000_FFFF
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic xferBits(input logic [7:0] tx, input int n, output logic [7:0] rx);
    rx = '0;
    for (int i = 7; i > 7 - n; i--) begin
      sck = 0; mosi = tx[i];
      tick(HALF);
      rx[i] = miso;
      sck = 1;
      tick(HALF);
    end
  endtask

  task automatic xferByte(input logic [7:0] tx, output logic [7:0] rx);
    xferBits(tx, 8, rx);
  endtask

  task automatic startFrame();
    selN = 0; tick(HALF);
  endtask

  task automatic endFrame();
    sck = 0; tick(HALF); selN = 1; tick(HALF + 4);
  endtask

  task automatic writeFrame(input logic [15:0] a);
    logic [7:0] r;
    startFrame();
    xferByte(8'h01, r); xferByte(a[15:8], r); xferByte(a[7:0], r);
    endFrame();
  endtask

  task automatic readFrame(output logic [31:0] got);
    logic [7:0] r;
    startFrame();
    xferByte(8'h02, r);
    for (int b = 3; b >= 0; b--) begin
      xferByte(8'h00, r); got[b*8 +: 8] = r;
    end
    endFrame();
  endtask

  initial begin
    int e0, o0;
    logic [7:0] r;
    logic [31:0] got;
    tick(5);
    // R8 reset state
    check("R8 oe in reset", {31'b0, misoOe}, 0);
    check("R8 exec in reset", {31'b0, execStrobe}, 0);
    check("R1 miso in reset", {31'b0, miso}, 0);
    rstN = 1; tick(4);

    // table walk
    for (int v = 0; v < 6; v++) begin
      logic [7:0]  c;
      logic [31:0] d;
      c = VEC[v][39:32]; d = VEC[v][31:0];
      e0 = execCount; o0 = oeCycles;
      if (c == 8'h01) begin
        writeFrame(d[15:0]);
        check("R3 exec count", execCount, e0 + 1);
        check("R3 args", {16'b0, lastArg}, {16'b0, d[15:0]});
      end else if (c == 8'h02) begin
        replyData = d;
        readFrame(got);
        check("R4 reply bits", got, d);
        check("R4 oe raised", {31'b0, oeCycles > o0}, 1);
        check("R4 oe released", {31'b0, misoOe}, 0);
      end else begin
        startFrame();
        xferByte(c, r); xferByte(d[15:8], r); xferByte(d[7:0], r);
        endFrame();
        check("R5 unknown no drive", oeCycles, o0);
        check("R5 unknown no exec", execCount, e0);
      end
      check("R9 command byte", {24'b0, cmdOut}, {24'b0, c});
    end

    // R1: activity while deselected
    e0 = execCount; o0 = oeCycles;
    xferByte(8'h01, r); xferByte(8'hAB, r); xferByte(8'hCD, r); sck = 0; tick(HALF);
    check("R1 deselected no exec", execCount, e0);
    check("R1 deselected no drive", oeCycles, o0);

    // R2: stray bits while deselected do not misalign next frame
    xferBits(8'hE0, 3, r); sck = 0; tick(HALF);
    writeFrame(16'h3C5A);
    check("R2 aligned args", {16'b0, lastArg}, 32'h3C5A);

    // R6: abort inside argument phase
    e0 = execCount;
    startFrame(); xferByte(8'h01, r); xferByte(8'hAA, r); xferBits(8'hBB, 4, r);
    endFrame();
    check("R6 abort no exec", execCount, e0);
    writeFrame(16'h1122);
    check("R6 fresh args after abort", {16'b0, lastArg}, 32'h1122);

    // R6: abort inside reply phase, oe released promptly
    replyData = 32'hF0F0_F0F0;
    startFrame(); xferByte(8'h02, r); xferByte(8'h00, r); xferBits(8'h00, 4, r);
    selN = 1; tick(4);
    check("R6 oe drop after deselect", {31'b0, misoOe}, 0);
    sck = 0; tick(HALF + 4);
    replyData = 32'hC3A5_0F96;
    readFrame(got);
    check("R6 reply restarts at MSB", got, 32'hC3A5_0F96);

    // R6: deselect coincides with final argument bit
    e0 = execCount;
    startFrame(); xferByte(8'h01, r); xferByte(8'h55, r); xferBits(8'h77, 7, r);
    sck = 0; mosi = 1; tick(HALF);
    sck = 1; selN = 1; tick(HALF);
    sck = 0; tick(HALF + 4);
    check("R6 coincident deselect no exec", execCount, e0);
    writeFrame(16'h6789);
    check("R6 next frame clean", {16'b0, lastArg}, 32'h6789);

    // R7: no clock after select -> off bus until deselect
    e0 = execCount; o0 = oeCycles;
    replyData = 32'hFFFF_FFFF;
    selN = 0; tick(100);
    xferByte(8'h02, r); xferByte(8'h00, r);
    xferByte(8'h01, r); xferByte(8'h12, r); xferByte(8'h34, r);
    endFrame();
    check("R7 watchdog no drive", oeCycles, o0);
    check("R7 watchdog no exec", execCount, e0);
    readFrame(got);
    check("R7 recovered after deselect", got, 32'hFFFF_FFFF);

    // R7: pause after first edge does not trip watchdog
    e0 = execCount;
    startFrame(); xferByte(8'h01, r); xferByte(8'h9A, r);
    tick(200);
    xferByte(8'hBC, r); endFrame();
    check("R7 pause after edge exec", execCount, e0 + 1);
    check("R7 pause after edge args", {16'b0, lastArg}, 32'h9ABC);

    // R8: reset during reply
    replyData = 32'hAAAA_AAAA;
    startFrame(); xferByte(8'h02, r); xferBits(8'h00, 3, r);
    rstN = 0; tick(2);
    check("R8 reset releases oe", {31'b0, misoOe}, 0);
    check("R8 reset miso low", {31'b0, miso}, 0);
    rstN = 1; endFrame();
    readFrame(got);
    check("R8 works after reset", got, 32'hAAAA_AAAA);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual running expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule